// File: doc/BRIEF.md
# Segmented Byte-Wide Memory Access Unit

This unit sits between an execution core and an 8-bit synchronous memory. The core presents a request made of a 16-bit offset, the code of the base register that produced the offset, an optional segment override, a direction and a size. The unit picks one of four segment registers and forms a 20-bit physical address. The address is the segment value moved up by four bit positions plus the offset, and it wraps at the top of the 1 MB space. The unit then runs one byte cycle on the memory port for a byte access, or two byte cycles for a 16-bit word.

Words are little-endian. The low byte sits at the physical address and the high byte at the next address up, so a write sends the low byte first and a read places the first returned byte in the low half of the result. The segment registers are loaded through a separate write port. A request is taken only while the unit is idle. Everything the transaction needs is captured in the cycle it is accepted, so a later change on the request or segment inputs cannot disturb it.

Top module: `seg_mem_unit`

## Requirements
- R1: After reset, mem_en and ready are 0, rdata is 0 and all four segment registers hold 0.
- R2: The physical address is (segment × 16 + offset) modulo 2^20. For example, segment 8888h with offset 1234h gives 89AB4h, and segment FFFFh with offset FFFFh gives 0FFEFh.
- R3: Without an override, req_base selects the segment. Base code 0 (instruction pointer) uses the code segment. Codes 1 (stack pointer) and 2 (frame pointer) use the stack segment. Codes 3 and 4 (source and destination index) and the unused codes 5 to 7 use the data segment.
- R4: When req_ovr_en is 1, req_ovr_sel chooses the segment, whatever the base code: 0 code, 1 data, 2 stack, 3 extra.
- R5: A write on the segment port with seg_wr_sel using the same 0–3 encoding changes only that register. It affects requests accepted in later cycles, not a request accepted on the same clock edge.
- R6: A byte read makes exactly one memory cycle. The memory returns data one cycle after mem_en. ready is high two cycles after the access cycle, with rdata = {8'h00, byte}.
- R7: A word read makes two memory cycles in consecutive clock cycles, at A and then A+1. rdata = {byte from A+1, byte from A}, and ready follows two cycles after the second access.
- R8: A word write drives req_wdata[7:0] to address A in the first cycle and req_wdata[15:8] to A+1 in the next. ready follows two cycles after the second access. A byte write drives req_wdata[7:0] in one cycle.
- R9: The second address of a word wraps modulo 2^20, so FFFFFh is followed by 00000h.
- R10: req_valid is accepted only when the unit is idle. The first memory cycle starts in the cycle after acceptance. Request inputs that are held or changed while a transaction runs cause no extra memory cycle and no change to the running one.
- R11: ready is a single-cycle pulse, once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Load a segment register |
| seg_wr_sel | input | 2 | Segment to load (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_base | input | 3 | Base register code used for default segment choice |
| req_ovr_en | input | 1 | Use req_ovr_sel instead of the default pairing |
| req_ovr_sel | input | 2 | Override segment |
| req_offset | input | 16 | Offset within the segment |
| req_wdata | input | 16 | Write data (low byte used for byte writes) |
| ready | output | 1 | Transaction complete pulse |
| rdata | output | 16 | Read result, valid with ready after a read |
| mem_en | output | 1 | Memory cycle strobe |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after a read strobe |

## Verification
The bench builds the unit with its default widths: 16-bit segments and offsets, a shift of four and an 8-bit data path. These values make the 20-bit wrap reachable. A segment of FFFFh with a large offset overflows past bit 19, and segment F000h with offset FFFFh puts the second byte of a word across the FFFFFh-to-00000h boundary. With the same widths, every base code and override value can be swept against four segment registers loaded with distinct values.

// File: rtl/seg_mem_pkg.sv
package seg_mem_pkg;
  localparam int SEG_COUNT = 4;
  localparam int SEL_W     = 2;
  localparam int BASE_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_sel_e;

  // Default pairing of base register code to segment, with override.
  function automatic seg_sel_e choose_seg(input logic [BASE_W-1:0] base,
                                          input logic ovr_en,
                                          input logic [SEL_W-1:0] ovr_sel);
    seg_sel_e pick;
    case (base)
      3'd0:       pick = SEG_CODE;
      3'd1, 3'd2: pick = SEG_STACK;
      default:    pick = SEG_DATA;
    endcase
    if (ovr_en) pick = seg_sel_e'(ovr_sel);
    return pick;
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_mem_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_seg
);
  logic [SEG_W-1:0] seg_q [SEG_COUNT];

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n)
        seg_q[g] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        seg_q[g] <= wr_data;
    end
  end

  assign rd_seg = seg_q[rd_sel];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] phys
);
  function automatic logic [ADDR_W-1:0] form_phys(input logic [SEG_W-1:0] s,
                                                  input logic [OFF_W-1:0] o);
    logic [ADDR_W-1:0] base_part;
    logic [ADDR_W-1:0] off_part;
    base_part = ADDR_W'(s) << SHIFT;
    off_part  = ADDR_W'(o);
    return base_part + off_part;
  endfunction

  assign phys = form_phys(seg, offset);
endmodule

// File: rtl/seg_byte_seq.sv
module seg_byte_seq #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic                  start_we,
  input  logic                  start_word,
  input  logic [2*DATA_W-1:0]   start_wdata,
  output logic                  idle,
  output logic                  second_cycle,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  ready,
  output logic [2*DATA_W-1:0]   rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACC0, ST_ACC1, ST_RESP} st_e;

  st_e                 state;
  logic [ADDR_W-1:0]   addr_q;
  logic                we_q;
  logic                word_q;
  logic [2*DATA_W-1:0] wdata_q;
  logic [2*DATA_W-1:0] rdata_q;
  logic                ready_q;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  assign idle         = (state == ST_IDLE);
  assign second_cycle = (state == ST_ACC1);
  assign mem_en       = (state == ST_ACC0) || (state == ST_ACC1);
  assign mem_we       = mem_en && we_q;
  assign mem_addr     = second_cycle ? step_addr(addr_q) : addr_q;
  assign mem_wdata    = second_cycle ? wdata_q[2*DATA_W-1:DATA_W] : wdata_q[DATA_W-1:0];
  assign ready        = ready_q;
  assign rdata        = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            addr_q  <= start_addr;
            we_q    <= start_we;
            word_q  <= start_word;
            wdata_q <= start_wdata;
            state   <= ST_ACC0;
          end
        end
        ST_ACC0: state <= word_q ? ST_ACC1 : ST_RESP;
        ST_ACC1: begin
          if (!we_q) rdata_q[DATA_W-1:0] <= mem_rdata;
          state <= ST_RESP;
        end
        ST_RESP: begin
          if (!we_q) begin
            if (word_q) rdata_q[2*DATA_W-1:DATA_W] <= mem_rdata;
            else        rdata_q <= {{DATA_W{1'b0}}, mem_rdata};
          end
          ready_q <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_mem_unit.sv
module seg_mem_unit
  import seg_mem_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                seg_wr_en,
  input  logic [SEL_W-1:0]    seg_wr_sel,
  input  logic [SEG_W-1:0]    seg_wr_data,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [BASE_W-1:0]   req_base,
  input  logic                req_ovr_en,
  input  logic [SEL_W-1:0]    req_ovr_sel,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [2*DATA_W-1:0] req_wdata,
  output logic                ready,
  output logic [2*DATA_W-1:0] rdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);
  seg_sel_e          seg_pick;
  logic [SEG_W-1:0]  cur_seg;
  logic [ADDR_W-1:0] phys_addr;
  logic              seq_idle;
  logic              acc_accept;
  logic              second_cycle;

  assign seg_pick   = choose_seg(req_base, req_ovr_en, req_ovr_sel);
  assign acc_accept = req_valid && seq_idle;

  seg_regfile #(.SEG_W(SEG_W)) u_segs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_wr_sel),
    .wr_data (seg_wr_data),
    .rd_sel  (seg_pick),
    .rd_seg  (cur_seg)
  );

  seg_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_agen (
    .seg    (cur_seg),
    .offset (req_offset),
    .phys   (phys_addr)
  );

  seg_byte_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (acc_accept),
    .start_addr   (phys_addr),
    .start_we     (req_write),
    .start_word   (req_word),
    .start_wdata  (req_wdata),
    .idle         (seq_idle),
    .second_cycle (second_cycle),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .ready        (ready),
    .rdata        (rdata)
  );
endmodule

// File: rtl/seg_mem_unit_chk.sv
module seg_mem_unit_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ready,
  input logic              acc_accept,
  input logic              second_cycle
);
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && second_cycle) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  p_dir_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && second_cycle) |-> ($past(mem_en) && (mem_we == $past(mem_we))));

  p_issue_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_accept |=> (mem_en && !second_cycle));

  p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !acc_accept);

  p_ready_after_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ($past(mem_en, 2) && !$past(mem_en)));
endmodule

bind seg_mem_unit seg_mem_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_en       (mem_en),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .ready        (ready),
  .acc_accept   (acc_accept),
  .second_cycle (second_cycle)
);

// File: tb/tb_seg_mem_unit.sv
`timescale 1ns/1ps
module tb_seg_mem_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_wr_en;
  logic [1:0]  seg_wr_sel;
  logic [15:0] seg_wr_data;
  logic        req_valid, req_write, req_word, req_ovr_en;
  logic [2:0]  req_base;
  logic [1:0]  req_ovr_sel;
  logic [15:0] req_offset, req_wdata;
  logic        ready;
  logic [15:0] rdata;
  logic        mem_en, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  seg_mem_unit dut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_base(req_base), .req_ovr_en(req_ovr_en), .req_ovr_sel(req_ovr_sel),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .ready(ready), .rdata(rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model and access log
  logic [7:0]  mem_m [bit [19:0]];
  logic [19:0] log_addr [256];
  logic        log_we   [256];
  logic [7:0]  log_wd   [256];
  int          log_n = 0;

  function automatic logic [7:0] fill(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction

  function automatic logic [7:0] peek(input logic [19:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return fill(a);
  endfunction

  function automatic logic [19:0] exp_pa(input logic [15:0] s, input logic [15:0] o);
    logic [23:0] sum;
    sum = {4'h0, s, 4'h0} + {8'h00, o};
    return sum[19:0];
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      log_addr[log_n[7:0]] = mem_addr;
      log_we[log_n[7:0]]   = mem_we;
      log_wd[log_n[7:0]]   = mem_wdata;
      if (mem_we) mem_m[mem_addr] = mem_wdata;
      else        mem_rdata <= peek(mem_addr);
      log_n <= log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic seg_load(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
    @(negedge clk);
    seg_wr_en = 1'b0;
  endtask

  task automatic issue(input logic we, input logic word, input logic [2:0] base,
                       input logic oen, input logic [1:0] osel,
                       input logic [15:0] off, input logic [15:0] wd,
                       output int lat, output int first);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_word = word; req_base = base;
    req_ovr_en = oen; req_ovr_sel = osel; req_offset = off; req_wdata = wd;
    first = log_n;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!ready && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    check(mem_en == 1'b0, "R1 mem_en", 32'(mem_en), 0);
    check(ready == 1'b0, "R1 ready", 32'(ready), 0);
    check(rdata == 16'h0, "R1 rdata", 32'(rdata), 0);
  endtask

  task automatic t_byte_read_basic;
    int lat, f;
    logic [19:0] a;
    seg_load(2'd0, 16'h8888);
    issue(1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 16'h1234, 16'h0, lat, f);
    a = exp_pa(16'h8888, 16'h1234);
    check(log_n - f == 1, "R6 access count", 32'(log_n - f), 1);
    check(log_addr[f[7:0]] == 20'h89AB4, "R2 address", 32'(log_addr[f[7:0]]), 32'h89AB4);
    check(lat == 3, "R6 latency", 32'(lat), 3);
    check(rdata == {8'h00, peek(a)}, "R6 rdata", 32'(rdata), 32'({8'h00, peek(a)}));
    @(negedge clk);
    check(ready == 1'b0, "R11 ready pulse", 32'(ready), 0);
  endtask

  task automatic t_pairing;
    int lat, f;
    logic [15:0] s;
    seg_load(2'd1, 16'h1000);
    seg_load(2'd2, 16'h2000);
    seg_load(2'd3, 16'h3000);
    for (int b = 0; b < 8; b++) begin
      s = (b == 0) ? 16'h8888 : (b == 1 || b == 2) ? 16'h2000 : 16'h1000;
      issue(1'b0, 1'b0, 3'(b), 1'b0, 2'd0, 16'h0040 + 16'(b), 16'h0, lat, f);
      check(log_addr[f[7:0]] == exp_pa(s, 16'h0040 + 16'(b)), "R3 default pairing",
            32'(log_addr[f[7:0]]), 32'(exp_pa(s, 16'h0040 + 16'(b))));
    end
  endtask

  task automatic t_override;
    int lat, f;
    logic [15:0] s;
    for (int k = 0; k < 4; k++) begin
      s = (k == 0) ? 16'h8888 : (k == 1) ? 16'h1000 : (k == 2) ? 16'h2000 : 16'h3000;
      issue(1'b0, 1'b0, 3'd1, 1'b1, 2'(k), 16'h0102, 16'h0, lat, f);
      check(log_addr[f[7:0]] == exp_pa(s, 16'h0102), "R4 override",
            32'(log_addr[f[7:0]]), 32'(exp_pa(s, 16'h0102)));
    end
  endtask

  task automatic t_word_rw;
    int lat, f;
    seg_load(2'd1, 16'h0072);
    issue(1'b1, 1'b1, 3'd3, 1'b0, 2'd0, 16'h0004, 16'hABCD, lat, f);
    check(log_n - f == 2, "R8 access count", 32'(log_n - f), 2);
    check(log_addr[f[7:0]] == 20'h00724 && log_wd[f[7:0]] == 8'hCD && log_we[f[7:0]],
          "R8 low byte first", 32'({log_addr[f[7:0]], log_wd[f[7:0]]}), 32'h0072_4CD);
    check(log_addr[8'(f + 1)] == 20'h00725 && log_wd[8'(f + 1)] == 8'hAB && log_we[8'(f + 1)],
          "R8 high byte second", 32'({log_addr[8'(f + 1)], log_wd[8'(f + 1)]}), 32'h0072_5AB);
    check(lat == 4, "R8 latency", 32'(lat), 4);
    issue(1'b0, 1'b1, 3'd4, 1'b0, 2'd0, 16'h0004, 16'h0, lat, f);
    check(rdata == 16'hABCD, "R7 word read", 32'(rdata), 32'hABCD);
    check(lat == 4 && log_n - f == 2, "R7 latency and count", 32'(lat), 4);
    issue(1'b0, 1'b0, 3'd3, 1'b0, 2'd0, 16'h0005, 16'h0, lat, f);
    check(rdata == 16'h00AB, "R6 byte from high address", 32'(rdata), 32'h00AB);
  endtask

  task automatic t_wrap;
    int lat, f;
    seg_load(2'd3, 16'hFFFF);
    issue(1'b1, 1'b0, 3'd0, 1'b1, 2'd3, 16'hFFFF, 16'h775A, lat, f);
    check(log_addr[f[7:0]] == 20'h0FFEF, "R2 wrap address", 32'(log_addr[f[7:0]]), 32'h0FFEF);
    check(log_n - f == 1 && log_wd[f[7:0]] == 8'h5A, "R8 byte write",
          32'(log_wd[f[7:0]]), 32'h5A);
    seg_load(2'd3, 16'hF000);
    issue(1'b1, 1'b1, 3'd0, 1'b1, 2'd3, 16'hFFFF, 16'h1234, lat, f);
    check(log_addr[f[7:0]] == 20'hFFFFF, "R9 first address", 32'(log_addr[f[7:0]]), 32'hFFFFF);
    check(log_addr[8'(f + 1)] == 20'h00000, "R9 wrapped second address",
          32'(log_addr[8'(f + 1)]), 0);
    issue(1'b0, 1'b1, 3'd0, 1'b1, 2'd3, 16'hFFFF, 16'h0, lat, f);
    check(rdata == 16'h1234, "R9 wrapped word read", 32'(rdata), 32'h1234);
  endtask

  task automatic t_busy_ignore;
    int n0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_base = 3'd3;
    req_ovr_en = 1'b0; req_offset = 16'h0004; req_wdata = 16'h0;
    n0 = log_n;
    @(negedge clk);
    req_write = 1'b1; req_word = 1'b0; req_offset = 16'h0300; req_wdata = 16'h00EE;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(ready == 1'b1 && rdata == 16'hABCD, "R10 running transaction kept",
          32'(rdata), 32'hABCD);
    repeat (4) @(negedge clk);
    check(log_n - n0 == 2, "R10 no extra access while busy", 32'(log_n - n0), 2);
    check(!mem_m.exists(exp_pa(16'h0072, 16'h0300)), "R10 ignored write absent",
          32'(peek(exp_pa(16'h0072, 16'h0300))), 32'(fill(exp_pa(16'h0072, 16'h0300))));
  endtask

  task automatic t_seg_same_edge;
    int lat, f;
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h4000;
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b0; req_base = 3'd3;
    req_ovr_en = 1'b0; req_offset = 16'h0000;
    f = log_n;
    @(negedge clk);
    seg_wr_en = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(log_addr[f[7:0]] == 20'h00720, "R5 old segment on same edge",
          32'(log_addr[f[7:0]]), 32'h00720);
    issue(1'b0, 1'b0, 3'd3, 1'b0, 2'd0, 16'h0000, 16'h0, lat, f);
    check(log_addr[f[7:0]] == 20'h40000, "R5 new segment later",
          32'(log_addr[f[7:0]]), 32'h40000);
    issue(1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 16'h0000, 16'h0, lat, f);
    check(log_addr[f[7:0]] == 20'h88880, "R5 other segment untouched",
          32'(log_addr[f[7:0]]), 32'h88880);
  endtask

  initial begin
    rst_n = 1'b0; seg_wr_en = 1'b0; seg_wr_sel = 2'd0; seg_wr_data = 16'h0;
    req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0; req_base = 3'd0;
    req_ovr_en = 1'b0; req_ovr_sel = 2'd0; req_offset = 16'h0; req_wdata = 16'h0;
    mem_rdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_read_basic();
    t_pairing();
    t_override();
    t_word_rw();
    t_wrap();
    t_busy_ignore();
    t_seg_same_edge();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule